// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Address Filtering

This block receives asynchronous serial frames on a single line for use on a shared multi-drop bus. In 9-bit mode each frame carries eight payload bits plus a ninth flag bit that tags the frame as an address word (flag 1) or a data word (flag 0). When address filtering is on, data words are discarded before they reach the host. A node can therefore sleep until a frame naming it arrives. After that it turns filtering off to take in the data words that follow.

The block keeps its own control and bit-rate registers. The host loads them through two write strobes. The receiver oversamples the line at sixteen times the bit rate, votes on three samples around the middle of each bit, and shifts the frame into an assembly register. It then moves the frame into a single-entry buffer. A ready flag marks unread data. The flag, gated by an enable input, drives the interrupt output. Status outputs report a framing error, an overrun, and the received ninth bit.

Top module: `nine_bit_uart_rx`

## Requirements
- R1: After reset all four control bits (enable = wdata bit 0, 9-bit mode = bit 1, continuous receive = bit 2, address filter = bit 3), the divisor and the speed select are 0. No frame is received until enable and continuous receive are both written to 1. All outputs are 0.
- R2: A frame is a low start bit, then 8 or 9 bits sent least significant bit first, then a stop bit. data_o shows bits 0 to 7 and bit9_o shows bit 8.
- R3: With 9-bit mode and the address filter on, a frame whose ninth bit is 0 is dropped. The buffer, ready_o and oerr_o are left unchanged, even when the buffer is full.
- R4: With the address filter off, every completed frame is loaded, whatever its ninth bit.
- R5: In 8-bit mode the address filter bit is ignored. Every frame is accepted and bit9_o reads 0.
- R6: ready_o sets when a frame is moved into the buffer and clears on the cycle after a rd_i pulse.
- R7: The bit time is 16 × (divisor + 1) clock cycles when baud_fast_i = 1 and 64 × (divisor + 1) when it is 0.
- R8: Each bit is a 2-of-3 majority of samples near mid-bit, so a one-sample glitch does not change the received value.
- R9: A stop bit that samples low sets ferr_o, and the frame is still loaded. A later good frame clears ferr_o.
- R10: A frame accepted while ready_o is set is discarded and sets oerr_o, and the buffer keeps the older word. While oerr_o is set no frame is received. Writing continuous receive to 0 clears oerr_o.
- R11: irq_o is ready_o AND irq_en_i.
- R12: A low pulse shorter than half a bit on an idle line is treated as noise and yields no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| ctl_we_i | input | 1 | Write strobe for the control bits |
| ctl_wdata_i | input | 4 | {addr_filter, cont_rx, mode9, enable} |
| baud_we_i | input | 1 | Write strobe for divisor and speed select |
| baud_div_i | input | 8 | Bit-rate divisor |
| baud_fast_i | input | 1 | 1 = ×16 prescale, 0 = ×64 prescale |
| rd_i | input | 1 | Host read of the buffer, one-cycle pulse |
| irq_en_i | input | 1 | Receive interrupt enable |
| data_o | output | 8 | Buffered payload |
| bit9_o | output | 1 | Buffered ninth bit |
| ferr_o | output | 1 | Framing error of the buffered frame |
| oerr_o | output | 1 | Overrun flag |
| ready_o | output | 1 | Buffer holds unread data |
| irq_o | output | 1 | Receive interrupt |

## Verification
The hardest state to reach from the ports is a filtered data frame arriving while the buffer already holds an unread address. Only that case shows that a dropped frame neither overwrites the buffer nor raises overrun. The bench reaches it by leaving an address frame unread, then sending a data frame with filtering on. Mid-bit glitches and sub-half-bit start pulses are placed cycle-exactly at the fastest rate, where one clock equals one oversample. A sweep over all 512 nine-bit values with filtering on covers the accept/drop split completely.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  typedef struct packed {
    logic addr_det;
    logic cont;
    logic mode9;
    logic en;
  } rx_ctl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_st_e;
endpackage

// File: rtl/uart9_ctl_regs.sv
module uart9_ctl_regs
  import uart9_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [3:0]       ctl_wdata_i,
  input  logic             baud_we_i,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic             baud_fast_i,
  output rx_ctl_t          ctl_o,
  output logic [DIV_W-1:0] div_o,
  output logic             fast_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o  <= '0;
      div_o  <= '0;
      fast_o <= 1'b0;
    end else begin
      if (ctl_we_i) ctl_o <= rx_ctl_t'(ctl_wdata_i);
      if (baud_we_i) begin
        div_o  <= baud_div_i;
        fast_o <= baud_fast_i;
      end
    end
  end
endmodule

// File: rtl/uart9_baud.sv
module uart9_baud #(
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned SLOW_SHIFT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             fast_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = DIV_W + SLOW_SHIFT;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // slow: 4*(div+1)-1 = {div, 2'b11}
  assign lim    = fast_i ? CNT_W'(div_i) : {div_i, {SLOW_SHIFT{1'b1}}};
  assign tick_o = run_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart9_rx_fsm.sv
module uart9_rx_fsm
  import uart9_pkg::*;
#(
  parameter int unsigned FRAME_W = 9,
  parameter int unsigned OSR_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               tick_i,
  input  logic               rxd_i,
  input  logic               mode9_i,
  output logic               done_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               stop_ok_o
);
  localparam logic [OSR_W-1:0] PH_MID  = OSR_W'((2 ** (OSR_W - 1)) + 1);
  localparam logic [OSR_W-1:0] PH_V0   = PH_MID - 2'd2;
  localparam logic [OSR_W-1:0] PH_V1   = PH_MID - 2'd1;
  localparam logic [OSR_W-1:0] PH_LAST = '1;
  localparam int unsigned IDX_W = $clog2(FRAME_W);

  rx_st_e             st_q;
  logic [OSR_W-1:0]   ph_q;
  logic [IDX_W-1:0]   idx_q;
  logic [1:0]         vote_q;
  logic [FRAME_W-1:0] sh_q;
  logic               maj;
  logic [IDX_W-1:0]   last_idx;

  assign maj      = (vote_q[0] & vote_q[1]) | (vote_q[0] & rxd_i) | (vote_q[1] & rxd_i);
  assign last_idx = mode9_i ? IDX_W'(FRAME_W - 1) : IDX_W'(FRAME_W - 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      idx_q  <= '0;
      vote_q <= '1;
      sh_q   <= '0;
    end else if (!run_i) begin
      st_q  <= ST_IDLE;
      ph_q  <= '0;
      idx_q <= '0;
    end else if (tick_i) begin
      ph_q <= ph_q + 1'b1;
      if (ph_q == PH_V0) vote_q[0] <= rxd_i;
      if (ph_q == PH_V1) vote_q[1] <= rxd_i;
      unique case (st_q)
        ST_IDLE: begin
          ph_q <= '0;
          if (!rxd_i) st_q <= ST_START;
        end
        ST_START: begin
          if (ph_q == PH_MID && maj) st_q <= ST_IDLE;
          else if (ph_q == PH_LAST) begin
            st_q  <= ST_DATA;
            idx_q <= '0;
          end
        end
        ST_DATA: begin
          if (ph_q == PH_MID) sh_q <= {maj, sh_q[FRAME_W-1:1]};
          if (ph_q == PH_LAST) begin
            if (idx_q == last_idx) st_q <= ST_STOP;
            else idx_q <= idx_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (ph_q == PH_MID) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o    = run_i && tick_i && (st_q == ST_STOP) && (ph_q == PH_MID);
  assign stop_ok_o = maj;
  // 8-bit frames finish one shift short: payload sits in the upper bits
  assign frame_o   = mode9_i ? sh_q : {1'b0, sh_q[FRAME_W-1:1]};
endmodule

// File: rtl/uart9_rx_buf.sv
module uart9_rx_buf #(
  parameter int unsigned FRAME_W = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               done_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               stop_ok_i,
  input  logic               mode9_i,
  input  logic               addr_det_i,
  input  logic               cont_i,
  input  logic               rd_i,
  output logic [FRAME_W-2:0] data_o,
  output logic               b8_o,
  output logic               ferr_o,
  output logic               ready_o,
  output logic               oerr_o
);
  logic accept;
  logic free;

  assign accept = !(mode9_i && addr_det_i && !frame_i[FRAME_W-1]);
  assign free   = !ready_o || rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      b8_o    <= 1'b0;
      ferr_o  <= 1'b0;
      ready_o <= 1'b0;
      oerr_o  <= 1'b0;
    end else begin
      if (!cont_i) oerr_o <= 1'b0;
      if (rd_i) ready_o <= 1'b0;
      if (done_i && accept) begin
        if (free) begin
          data_o  <= frame_i[FRAME_W-2:0];
          b8_o    <= frame_i[FRAME_W-1];
          ferr_o  <= !stop_ok_i;
          ready_o <= 1'b1;
        end else begin
          oerr_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nine_bit_uart_rx.sv
module nine_bit_uart_rx
  import uart9_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SLOW_SHIFT  = 2,
  parameter int unsigned OSR_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             ctl_we_i,
  input  logic [3:0]       ctl_wdata_i,
  input  logic             baud_we_i,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic             baud_fast_i,
  input  logic             rd_i,
  input  logic             irq_en_i,
  output logic [7:0]       data_o,
  output logic             bit9_o,
  output logic             ferr_o,
  output logic             oerr_o,
  output logic             ready_o,
  output logic             irq_o
);
  localparam int unsigned FRAME_W = 9;

  rx_ctl_t            ctl_q;
  logic [DIV_W-1:0]   div_q;
  logic               fast_q;
  logic               run;
  logic               tick;
  logic [SYNC_STAGES-1:0] sync_q;
  logic               rxd;
  logic               frame_done;
  logic [FRAME_W-1:0] frame_bits;
  logic               stop_ok;

  uart9_ctl_regs #(.DIV_W(DIV_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_we_i    (ctl_we_i),
    .ctl_wdata_i (ctl_wdata_i),
    .baud_we_i   (baud_we_i),
    .baud_div_i  (baud_div_i),
    .baud_fast_i (baud_fast_i),
    .ctl_o       (ctl_q),
    .div_o       (div_q),
    .fast_o      (fast_q)
  );

  assign run = ctl_q.en && ctl_q.cont && !oerr_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
  end
  assign rxd = sync_q[SYNC_STAGES-1];

  uart9_baud #(.DIV_W(DIV_W), .SLOW_SHIFT(SLOW_SHIFT)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div_q),
    .fast_i (fast_q),
    .tick_o (tick)
  );

  uart9_rx_fsm #(.FRAME_W(FRAME_W), .OSR_W(OSR_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .tick_i    (tick),
    .rxd_i     (rxd),
    .mode9_i   (ctl_q.mode9),
    .done_o    (frame_done),
    .frame_o   (frame_bits),
    .stop_ok_o (stop_ok)
  );

  uart9_rx_buf #(.FRAME_W(FRAME_W)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (frame_done),
    .frame_i    (frame_bits),
    .stop_ok_i  (stop_ok),
    .mode9_i    (ctl_q.mode9),
    .addr_det_i (ctl_q.addr_det),
    .cont_i     (ctl_q.cont),
    .rd_i       (rd_i),
    .data_o     (data_o),
    .b8_o       (bit9_o),
    .ferr_o     (ferr_o),
    .ready_o    (ready_o),
    .oerr_o     (oerr_o)
  );

  assign irq_o = ready_o & irq_en_i;
endmodule

// File: rtl/uart9_rx_chk.sv
module uart9_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_i,
  input logic       ctl_we_i,
  input logic       irq_en_i,
  input logic       irq_o,
  input logic       ready_o,
  input logic       oerr_o,
  input logic [7:0] data_o,
  input logic       frame_done,
  input logic [8:0] frame_bits,
  input logic       mode9,
  input logic       addr_det,
  input logic       cont
);
  logic drop;
  assign drop = mode9 && addr_det && !frame_bits[8];

  AST_FILTER_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done && drop |=> $stable(data_o) && (ready_o == ($past(ready_o) && !$past(rd_i)))); // R3
  AST_LOAD_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done && !drop && (!ready_o || rd_i) |=> ready_o && (data_o == $past(frame_bits[7:0]))); // R4
  AST_MODE8_NO_B8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done && !mode9 |-> !frame_bits[8]); // R5
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !frame_done |=> !ready_o); // R6
  AST_OVERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done && !drop && ready_o && !rd_i && !ctl_we_i |=> oerr_o && $stable(data_o)); // R10
  AST_OVERRUN_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oerr_o |-> !frame_done); // R10
  AST_OVERRUN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cont |=> !oerr_o); // R10
  AST_IRQ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o); // R11
  AST_IRQ_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ready_o); // R11
endmodule

bind nine_bit_uart_rx uart9_rx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_i       (rd_i),
  .ctl_we_i   (ctl_we_i),
  .irq_en_i   (irq_en_i),
  .irq_o      (irq_o),
  .ready_o    (ready_o),
  .oerr_o     (oerr_o),
  .data_o     (data_o),
  .frame_done (frame_done),
  .frame_bits (frame_bits),
  .mode9      (ctl_q.mode9),
  .addr_det   (ctl_q.addr_det),
  .cont       (ctl_q.cont)
);

// File: tb/tb_nine_bit_uart_rx.sv
module tb_nine_bit_uart_rx;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx = 1'b1;
  logic       ctl_we = 1'b0;
  logic [3:0] ctl_wdata = '0;
  logic       baud_we = 1'b0;
  logic [7:0] baud_div = '0;
  logic       baud_fast = 1'b0;
  logic       rd = 1'b0;
  logic       irq_en = 1'b0;
  logic [7:0] data;
  logic       bit9, ferr, oerr, ready, irq;

  int n_chk = 0;
  int n_fail = 0;
  int bit_clks = 64;

  always #2 clk = ~clk;

  nine_bit_uart_rx dut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_i(rx),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .baud_we_i(baud_we), .baud_div_i(baud_div), .baud_fast_i(baud_fast),
    .rd_i(rd), .irq_en_i(irq_en),
    .data_o(data), .bit9_o(bit9), .ferr_o(ferr), .oerr_o(oerr),
    .ready_o(ready), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic en, input logic m9, input logic cont, input logic adr);
    @(negedge clk);
    ctl_wdata = {adr, cont, m9, en};
    ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic set_baud(input int div, input logic fast);
    @(negedge clk);
    baud_div = 8'(div);
    baud_fast = fast;
    baud_we = 1'b1;
    @(negedge clk);
    baud_we = 1'b0;
    bit_clks = fast ? (div + 1) * 16 : (div + 1) * 64;
  endtask

  // glitch_bit: payload index to hit with a one-clock inverted sample at offset 10
  task automatic send(input logic [8:0] v, input int nb, input logic stop_v, input int glitch_bit);
    @(negedge clk);
    rx = 1'b0;
    repeat (bit_clks) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      for (int c = 0; c < bit_clks; c++) begin
        rx = (i == glitch_bit && c == 10) ? ~v[i] : v[i];
        @(negedge clk);
      end
    end
    rx = stop_v;
    repeat (bit_clks) @(negedge clk);
    rx = 1'b1;
    repeat (bit_clks) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 ready", ready, 0);
    chk("R1 oerr", oerr, 0);
    chk("R1 ferr", ferr, 0);
    chk("R1 data", data, 0);
    chk("R1 bit9", bit9, 0);
    chk("R1 irq", irq, 0);
    // R1: controls reset to 0, so nothing is received
    send(9'h055, 8, 1'b1, -1);
    chk("R1 disabled no frame", ready, 0);

    set_baud(0, 1'b1);
    irq_en = 1'b1;
    // R5: 8-bit mode with filter bit set, all frames accepted
    wr_ctl(1'b1, 1'b0, 1'b1, 1'b1);
    for (int v = 0; v < 256; v += 5) begin
      send(9'(v), 8, 1'b1, -1);
      chk("R5 ready", ready, 1);
      chk("R2 data8", data, v);
      chk("R5 bit9 zero", bit9, 0);
      chk("R11 irq follows ready", irq, 1);
      do_read();
      chk("R6 read clears", ready, 0);
    end

    // R3: 9-bit mode with filter, all 512 values
    wr_ctl(1'b1, 1'b1, 1'b1, 1'b1);
    for (int v = 0; v < 512; v++) begin
      send(9'(v), 9, 1'b1, -1);
      if (v >= 256) begin
        chk("R3 address accepted", ready, 1);
        chk("R2 data9", data, v & 8'hFF);
        chk("R2 bit9", bit9, 1);
        do_read();
      end else begin
        chk("R3 data dropped", ready, 0);
      end
    end

    // R3: dropped frame leaves a full buffer alone
    send(9'h1C3, 9, 1'b1, -1);
    send(9'h03C, 9, 1'b1, -1);
    chk("R3 full ready", ready, 1);
    chk("R3 full data kept", data, 8'hC3);
    chk("R3 no overrun", oerr, 0);
    do_read();

    // R4: filter off, data frames loaded
    wr_ctl(1'b1, 1'b1, 1'b1, 1'b0);
    send(9'h0AA, 9, 1'b1, -1);
    chk("R4 ready", ready, 1);
    chk("R4 data", data, 8'hAA);
    chk("R4 bit9", bit9, 0);
    do_read();
    send(9'h155, 9, 1'b1, -1);
    chk("R4 addr data", data, 8'h55);
    chk("R4 addr bit9", bit9, 1);
    do_read();

    // R8: single-sample glitches
    send(9'h000, 9, 1'b1, 3);
    chk("R8 glitch high", data, 8'h00);
    do_read();
    send(9'h1FF, 9, 1'b1, 5);
    chk("R8 glitch low", data, 8'hFF);
    chk("R8 glitch low bit9", bit9, 1);
    do_read();

    // R12: short low pulse
    @(negedge clk);
    rx = 1'b0;
    repeat (3) @(negedge clk);
    rx = 1'b1;
    repeat (48) @(negedge clk);
    chk("R12 no frame", ready, 0);
    send(9'h066, 9, 1'b1, -1);
    chk("R12 recovers", data, 8'h66);
    do_read();

    // R9: framing error
    send(9'h0A5, 9, 1'b0, -1);
    chk("R9 ferr", ferr, 1);
    chk("R9 loaded", ready, 1);
    chk("R9 data", data, 8'hA5);
    do_read();
    send(9'h05A, 9, 1'b1, -1);
    chk("R9 ferr clears", ferr, 0);
    do_read();

    // R10: overrun
    send(9'h011, 9, 1'b1, -1);
    send(9'h022, 9, 1'b1, -1);
    chk("R10 oerr", oerr, 1);
    chk("R10 kept first", data, 8'h11);
    // R11: mask
    irq_en = 1'b0;
    @(negedge clk);
    chk("R11 masked", irq, 0);
    irq_en = 1'b1;
    do_read();
    send(9'h033, 9, 1'b1, -1);
    chk("R10 halted", ready, 0);
    wr_ctl(1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R10 cleared", oerr, 0);
    wr_ctl(1'b1, 1'b1, 1'b1, 1'b0);
    send(9'h044, 9, 1'b1, -1);
    chk("R10 resumes", data, 8'h44);
    do_read();

    // R7: other rates
    set_baud(2, 1'b1);
    send(9'h1A7, 9, 1'b1, -1);
    chk("R7 div2 data", data, 8'hA7);
    chk("R7 div2 bit9", bit9, 1);
    do_read();
    set_baud(0, 1'b0);
    send(9'h05C, 9, 1'b1, -1);
    chk("R7 slow data", data, 8'h5C);
    chk("R7 slow ready", ready, 1);
    do_read();

    finish_run();
  end
endmodule